// File: doc/BRIEF.md
# Five-Stage Pipeline Control Unit with Delay Slot and Shadow Squash

This unit steers an in-order five-stage instruction pipeline (fetch, decode, execute, memory, write-back). It owns the program counter and one control register per stage. Each stage register holds a valid bit together with the control fields decoded once in the decode stage: ALU operation, immediate-operand select, memory read and write requests, register-write request and destination, a branch marker and an overflow-check marker. The fields travel with the instruction, so every stage acts on the instruction it currently holds.

Every instruction writes the register file from the last stage, so R-type results pass the memory stage idle and one write port suffices. A branch-if-equal is resolved in execute from an external equality flag. The instruction directly after the branch always completes. The next instruction, fetched while the branch resolves, is kept in the pipe but loses its valid bit, and an invalid stage drives no side effects. A load followed in decode by an instruction that reads the loaded register costs one bubble: the fetch side holds and an invalid slot enters execute.

The unit is used next to a datapath that reads `rs_addr_o`/`rt_addr_o`, computes in execute, and signals `br_eq_i` and `alu_ovf_i` for the instruction that is in execute in the same cycle.

Top module: `pipe_ctl`

## Requirements
- R1: The register write enable `wb_we_o` is raised only for an instruction in the write-back stage, one cycle after that instruction left the memory stage; an R-type instruction in the memory stage drives both memory enables low.
- R2: Stores, branches and any instruction whose destination field is register 0 never raise `wb_we_o`; the store destination is never written.
- R3: A valid branch (opcode 0x04) in execute with `br_eq_i` high raises `pc_sel_o`; on the next cycle `pc_o` equals the branch address plus 4 plus the sign-extended 16-bit immediate times 4.
- R4: The single instruction after a taken branch completes normally: it writes back and may raise `ovf_trap_o`.
- R5: The second instruction after a taken branch enters decode with its valid bit clear; it never writes back and never raises `ovf_trap_o`.
- R6: If decode holds an instruction that reads (through rs, or through rt for R-type, store and branch) the non-zero destination of a load in execute, `fetch_hold_o` rises; on the next cycle `pc_o` and decode are unchanged and the execute stage is invalid.
- R7: Without hold or redirect, `pc_o` advances by 4 each cycle.
- R8: A stage whose valid bit is clear drives its memory read, memory write, register write and overflow outputs low, whatever fields it carries.
- R9: Synchronous active-low reset sets `pc_o` to 0 and clears every valid bit.
- R10: A branch in execute with `br_eq_i` low leaves `pc_sel_o` low and both following instructions complete.
- R11: A load does not stall a following instruction that names its destination only in a field it does not read (for example the rt destination of an OR-immediate).
- R12: Decode maps opcodes 0x00 (R-type, funct 0x20 add, 0x22 sub, 0x24 and, 0x25 or), 0x23 load, 0x2B store, 0x04 branch, 0x0D or-immediate and 0x08 add-immediate to `ex_alu_fn_o` codes add=0, sub=1, and=2, or=3, with `ex_use_imm_o` set for the immediate, load and store forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word fetched at `pc_o` |
| br_eq_i | input | 1 | Operands of the instruction in execute are equal |
| alu_ovf_i | input | 1 | ALU signed overflow for the instruction in execute |
| pc_o | output | ADDR_W | Fetch address |
| pc_sel_o | output | 1 | Redirect to the branch target at the end of this cycle |
| fetch_hold_o | output | 1 | Load-use stall: PC and decode hold, bubble to execute |
| id_valid_o | output | 1 | Decode stage holds a live instruction |
| rs_addr_o | output | 5 | First register-file read address from decode |
| rt_addr_o | output | 5 | Second register-file read address from decode |
| ex_valid_o | output | 1 | Execute stage holds a live instruction |
| ex_alu_fn_o | output | 2 | ALU operation code in execute |
| ex_use_imm_o | output | 1 | Execute uses the immediate as second operand |
| ovf_trap_o | output | 1 | Overflow reported by a live overflow-checked instruction |
| mem_valid_o | output | 1 | Memory stage holds a live instruction |
| mem_rd_en_o | output | 1 | Data memory read request |
| mem_wr_en_o | output | 1 | Data memory write request |
| wb_valid_o | output | 1 | Write-back stage holds a live instruction |
| wb_we_o | output | 1 | Register-file write enable |
| wb_dst_o | output | 5 | Register-file write address |

## Verification
The bench builds the unit with `ADDR_W` set to 16, which keeps the whole fetch window inside a 32-word program and lets a positive branch offset of 15 words land at address 0x40 inside that window. Short directed programs bring within reach the exact cycle of each event: the first write-back four cycles after release, the redirect and squash around a taken branch, the single bubble of a load-use pair on rs and on rt, and the non-stall of a destination-only match. Overflow is forced high around a taken branch so both the delay slot and the squashed shadow instruction meet it.

// File: rtl/pipe_ctl_pkg.sv
// Package: shared encodings and the per-stage control record.
// Assumes a fixed 32-bit instruction format with 6-bit opcode,
// 5-bit register fields and a 16-bit immediate.
package pipe_ctl_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_AW  = 5;
    localparam int IMM_W   = 16;

    localparam logic [5:0] OPC_ALU  = 6'h00;
    localparam logic [5:0] OPC_LD   = 6'h23;
    localparam logic [5:0] OPC_ST   = 6'h2B;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_ADDI = 6'h08;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_fn_e;

    // Control carried alongside an instruction from decode onwards.
    typedef struct packed {
        logic              valid;
        alu_fn_e           alu_fn;
        logic              use_imm;
        logic              mem_rd;
        logic              mem_wr;
        logic              reg_we;
        logic [REG_AW-1:0] dst;
        logic              is_br;
        logic              ovf_chk;
    } stage_ctl_t;

endpackage

// File: rtl/pc_gen.sv
// Module: pc_gen
// Holds the fetch address. Redirect wins over hold; otherwise the
// address steps by one instruction word. Assumes redirect and hold
// are never raised together by the caller.
module pc_gen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] target,
    input  logic              hold,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    // Next fetch address selection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (redirect)
            pc <= target;
        else if (!hold)
            pc <= pc + STEP;
    end

    a_r3_redirect_lands: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> pc == $past(target));

    a_r7_step_by_four: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !hold) |=> pc == $past(pc) + STEP);

    a_r6_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !redirect) |=> $stable(pc));

endmodule

// File: rtl/ctl_decode.sv
// Module: ctl_decode
// Turns the instruction held in decode into the control record that
// travels down the pipe, the register read addresses, which of them
// are really read, and the branch target. Purely combinational.
// Assumes the word is the one fetched at pc_id.
module ctl_decode
    import pipe_ctl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               valid,
    input  logic [ADDR_W-1:0]  pc_id,
    output stage_ctl_t         ctl,
    output logic [REG_AW-1:0]  rs,
    output logic [REG_AW-1:0]  rt,
    output logic               reads_rs,
    output logic               reads_rt,
    output logic [ADDR_W-1:0]  br_target
);

    logic [5:0]        opc;
    logic [5:0]        fn;
    logic [REG_AW-1:0] rd;
    logic [IMM_W-1:0]  imm;
    logic [ADDR_W-1:0] offset;

    assign opc = instr[31:26];
    assign rs  = instr[25:21];
    assign rt  = instr[20:16];
    assign rd  = instr[15:11];
    assign fn  = instr[5:0];
    assign imm = instr[15:0];

    // Word offset, sign-extended and scaled to bytes.
    assign offset    = ADDR_W'($signed({imm, 2'b00}));
    assign br_target = pc_id + ADDR_W'(4) + offset;

    // Opcode and function decode into stage control fields.
    always_comb begin
        ctl          = '0;
        ctl.valid    = valid;
        ctl.alu_fn   = ALU_ADD;
        reads_rs     = 1'b0;
        reads_rt     = 1'b0;
        unique case (opc)
            OPC_ALU: begin
                reads_rs = 1'b1;
                reads_rt = 1'b1;
                ctl.dst  = rd;
                ctl.reg_we = (rd != '0);
                unique case (fn)
                    FN_SUB: begin ctl.alu_fn = ALU_SUB; ctl.ovf_chk = 1'b1; end
                    FN_AND: ctl.alu_fn = ALU_AND;
                    FN_OR:  ctl.alu_fn = ALU_OR;
                    FN_ADD: begin ctl.alu_fn = ALU_ADD; ctl.ovf_chk = 1'b1; end
                    default: ctl.alu_fn = ALU_ADD;
                endcase
            end
            OPC_LD: begin
                reads_rs    = 1'b1;
                ctl.use_imm = 1'b1;
                ctl.mem_rd  = 1'b1;
                ctl.dst     = rt;
                ctl.reg_we  = (rt != '0);
            end
            OPC_ST: begin
                reads_rs    = 1'b1;
                reads_rt    = 1'b1;
                ctl.use_imm = 1'b1;
                ctl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                reads_rs   = 1'b1;
                reads_rt   = 1'b1;
                ctl.alu_fn = ALU_SUB;
                ctl.is_br  = 1'b1;
            end
            OPC_ORI: begin
                reads_rs    = 1'b1;
                ctl.alu_fn  = ALU_OR;
                ctl.use_imm = 1'b1;
                ctl.dst     = rt;
                ctl.reg_we  = (rt != '0);
            end
            OPC_ADDI: begin
                reads_rs    = 1'b1;
                ctl.use_imm = 1'b1;
                ctl.ovf_chk = 1'b1;
                ctl.dst     = rt;
                ctl.reg_we  = (rt != '0);
            end
            default: ;
        endcase
    end

    // A store or branch never asks for a register write.
    always_comb begin
        a_r2_no_store_write: assert (!(ctl.mem_wr || ctl.is_br) || !ctl.reg_we);
    end

endmodule

// File: rtl/hazard_detect.sv
// Module: hazard_detect
// Flags a load-use pair: a live load in execute whose non-zero
// destination is read by the live instruction in decode. Assumes the
// loaded value is only available after the memory stage.
module hazard_detect
    import pipe_ctl_pkg::*;
(
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              id_reads_rs,
    input  logic              id_reads_rt,
    input  stage_ctl_t        ex_ctl,
    output logic              stall
);

    logic ex_load;
    logic hit_rs;
    logic hit_rt;

    // Compare the decode sources against the pending load destination.
    always_comb begin
        ex_load = ex_ctl.valid && ex_ctl.mem_rd && (ex_ctl.dst != '0);
        hit_rs  = id_reads_rs && (id_rs == ex_ctl.dst);
        hit_rt  = id_reads_rt && (id_rt == ex_ctl.dst);
        stall   = id_valid && ex_load && (hit_rs || hit_rt);
    end

endmodule

// File: rtl/pipe_ctl.sv
// Module: pipe_ctl (top)
// Data-stationary control for a five-stage in-order pipeline. Owns
// the PC, the decode instruction register and the control records of
// execute, memory and write-back. Branches resolve in execute with one
// delay slot; the next wrong-path instruction is squashed through its
// valid bit. Load-use pairs cost one bubble. Assumes br_eq_i and
// alu_ovf_i refer to the instruction currently in execute.
module pipe_ctl
    import pipe_ctl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [31:0]             instr_i,
    input  logic                    br_eq_i,
    input  logic                    alu_ovf_i,
    output logic [ADDR_W-1:0]       pc_o,
    output logic                    pc_sel_o,
    output logic                    fetch_hold_o,
    output logic                    id_valid_o,
    output logic [4:0]              rs_addr_o,
    output logic [4:0]              rt_addr_o,
    output logic                    ex_valid_o,
    output logic [1:0]              ex_alu_fn_o,
    output logic                    ex_use_imm_o,
    output logic                    ovf_trap_o,
    output logic                    mem_valid_o,
    output logic                    mem_rd_en_o,
    output logic                    mem_wr_en_o,
    output logic                    wb_valid_o,
    output logic                    wb_we_o,
    output logic [4:0]              wb_dst_o
);

    // Decode stage storage.
    logic               id_valid;
    logic [INSTR_W-1:0] id_instr;
    logic [ADDR_W-1:0]  id_pc;

    // Later stage control records.
    stage_ctl_t         ex_ctl;
    stage_ctl_t         mem_ctl;
    stage_ctl_t         wb_ctl;
    logic [ADDR_W-1:0]  ex_target;

    // Decode results.
    stage_ctl_t         id_ctl;
    logic [REG_AW-1:0]  id_rs;
    logic [REG_AW-1:0]  id_rt;
    logic               id_reads_rs;
    logic               id_reads_rt;
    logic [ADDR_W-1:0]  id_target;

    logic               stall;
    logic               taken;

    pc_gen #(.ADDR_W(ADDR_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (taken),
        .target   (ex_target),
        .hold     (stall),
        .pc       (pc_o)
    );

    ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .instr     (id_instr),
        .valid     (id_valid),
        .pc_id     (id_pc),
        .ctl       (id_ctl),
        .rs        (id_rs),
        .rt        (id_rt),
        .reads_rs  (id_reads_rs),
        .reads_rt  (id_reads_rt),
        .br_target (id_target)
    );

    hazard_detect u_haz (
        .id_valid    (id_valid),
        .id_rs       (id_rs),
        .id_rt       (id_rt),
        .id_reads_rs (id_reads_rs),
        .id_reads_rt (id_reads_rt),
        .ex_ctl      (ex_ctl),
        .stall       (stall)
    );

    // Branch resolution in execute.
    assign taken = ex_ctl.valid && ex_ctl.is_br && br_eq_i;

    // Fetch-to-decode register: holds on stall, loses valid on redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_valid <= 1'b0;
            id_instr <= '0;
            id_pc    <= '0;
        end else if (!stall) begin
            id_valid <= !taken;
            id_instr <= instr_i;
            id_pc    <= pc_o;
        end
    end

    // Decode-to-execute register: a cleared record is the bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_ctl    <= '0;
            ex_target <= '0;
        end else if (stall) begin
            ex_ctl    <= '0;
            ex_target <= '0;
        end else begin
            ex_ctl    <= id_ctl;
            ex_target <= id_target;
        end
    end

    // Execute-to-memory and memory-to-write-back registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ctl <= '0;
            wb_ctl  <= '0;
        end else begin
            mem_ctl <= ex_ctl;
            wb_ctl  <= mem_ctl;
        end
    end

    // Port drive: every side effect is qualified by its stage's valid bit.
    always_comb begin
        pc_sel_o     = taken;
        fetch_hold_o = stall;
        id_valid_o   = id_valid;
        rs_addr_o    = id_rs;
        rt_addr_o    = id_rt;
        ex_valid_o   = ex_ctl.valid;
        ex_alu_fn_o  = ex_ctl.alu_fn;
        ex_use_imm_o = ex_ctl.use_imm;
        ovf_trap_o   = ex_ctl.valid && ex_ctl.ovf_chk && alu_ovf_i;
        mem_valid_o  = mem_ctl.valid;
        mem_rd_en_o  = mem_ctl.valid && mem_ctl.mem_rd;
        mem_wr_en_o  = mem_ctl.valid && mem_ctl.mem_wr;
        wb_valid_o   = wb_ctl.valid;
        wb_we_o      = wb_ctl.valid && wb_ctl.reg_we;
        wb_dst_o     = wb_ctl.dst;
    end

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && !id_valid_o && !ex_valid_o && !mem_valid_o && !wb_valid_o));

    a_r1_write_follows_mem: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we_o |-> $past(mem_valid_o) && !$past(mem_wr_en_o));

    a_r5_shadow_squashed: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_o |=> !id_valid_o);

    a_r6_bubble_enters: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hold_o |=> !ex_valid_o && $stable(rs_addr_o) && $stable(rt_addr_o));

    a_r8_dead_stage_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid_o |-> !mem_rd_en_o && !mem_wr_en_o);

endmodule

// File: tb/pipe_ctl_tb.sv
module pipe_ctl_tb;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   instr;
    logic          br_eq = 1'b0;
    logic          alu_ovf = 1'b0;
    logic [AW-1:0] pc;
    logic          pc_sel, hold, id_v, ex_v, ex_imm, ovf, mem_v, mem_rd, mem_wr, wb_v, wb_we;
    logic [4:0]    rs_a, rt_a, wb_dst;
    logic [1:0]    ex_fn;

    logic [31:0]   prog [0:31];
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    assign instr = prog[pc[6:2]];

    pipe_ctl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .br_eq_i(br_eq), .alu_ovf_i(alu_ovf),
        .pc_o(pc), .pc_sel_o(pc_sel), .fetch_hold_o(hold), .id_valid_o(id_v),
        .rs_addr_o(rs_a), .rt_addr_o(rt_a), .ex_valid_o(ex_v), .ex_alu_fn_o(ex_fn),
        .ex_use_imm_o(ex_imm), .ovf_trap_o(ovf), .mem_valid_o(mem_v),
        .mem_rd_en_o(mem_rd), .mem_wr_en_o(mem_wr), .wb_valid_o(wb_v),
        .wb_we_o(wb_we), .wb_dst_o(wb_dst)
    );

    function automatic logic [31:0] rop(input logic [5:0] fn, input logic [4:0] s,
                                        input logic [4:0] t, input logic [4:0] d);
        return {6'h00, s, t, d, 5'd0, fn};
    endfunction

    function automatic logic [31:0] iop(input logic [5:0] op, input logic [4:0] s,
                                        input logic [4:0] t, input logic [15:0] imm);
        return {op, s, t, imm};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reset with a cleared program; caller fills prog before release.
    task automatic clear_prog();
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) prog[i] = 32'h0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Release reset at a falling edge: cycle 0 is now.
    task automatic release_rst();
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Mixed stream: write-back timing, stores, decode mapping.
    task automatic t_mixed();
        clear_prog();
        prog[0] = rop(6'h20, 5'd1, 5'd2, 5'd3);
        prog[1] = iop(6'h23, 5'd1, 5'd5, 16'd8);
        prog[2] = iop(6'h2B, 5'd2, 5'd6, 16'd4);
        prog[3] = iop(6'h0D, 5'd4, 5'd7, 16'h00FF);
        prog[4] = rop(6'h20, 5'd1, 5'd2, 5'd0);
        release_rst();
        check("R9 pc after reset", 32'(pc), 0);
        check("R9 valids after reset", {id_v, ex_v, mem_v, wb_v, wb_we}, 0);
        step(1);
        check("R7 pc step", 32'(pc), 4);
        check("R9 decode live", 32'(id_v), 1);
        step(1);
        check("R7 pc step 2", 32'(pc), 8);
        check("R12 add fn", 32'(ex_fn), 0);
        check("R12 add no imm", 32'(ex_imm), 0);
        step(1);
        check("R1 r-type idle in mem", {mem_v, mem_rd, mem_wr, wb_we}, 32'b1000);
        check("R12 load uses imm", 32'(ex_imm), 1);
        step(1);
        check("R1 r-type write", {wb_we, wb_dst}, {1'b1, 5'd3});
        check("R12 load reads mem", 32'(mem_rd), 1);
        step(1);
        check("R1 load write", {wb_we, wb_dst}, {1'b1, 5'd5});
        check("R12 store writes mem", 32'(mem_wr), 1);
        check("R12 ori fn", {ex_fn, ex_imm}, {2'd3, 1'b1});
        step(1);
        check("R2 store no write", {wb_v, wb_we}, 2'b10);
        step(1);
        check("R1 ori write", {wb_we, wb_dst}, {1'b1, 5'd7});
        step(1);
        check("R2 dest zero no write", {wb_v, wb_we}, 2'b10);
    endtask

    // Taken branch: delay slot completes, shadow squashed, overflow forced.
    task automatic t_taken();
        clear_prog();
        br_eq = 1'b1;
        alu_ovf = 1'b1;
        prog[0]  = iop(6'h04, 5'd6, 5'd7, 16'd15);
        prog[1]  = rop(6'h20, 5'd1, 5'd2, 5'd4);
        prog[2]  = rop(6'h20, 5'd1, 5'd2, 5'd8);
        prog[16] = rop(6'h25, 5'd1, 5'd2, 5'd9);
        release_rst();
        step(2);
        check("R3 redirect raised", 32'(pc_sel), 1);
        check("R12 branch no overflow", 32'(ovf), 0);
        step(1);
        check("R3 target pc", 32'(pc), 32'h40);
        check("R5 shadow invalid", 32'(id_v), 0);
        check("R4 delay slot overflow", 32'(ovf), 1);
        step(1);
        check("R5 shadow no overflow", 32'(ovf), 0);
        check("R2 branch no write", 32'(wb_we), 0);
        step(1);
        check("R4 delay slot write", {wb_we, wb_dst}, {1'b1, 5'd4});
        step(1);
        check("R5 shadow no write", {wb_v, wb_we}, 2'b00);
        step(1);
        check("R3 target write", {wb_we, wb_dst}, {1'b1, 5'd9});
        br_eq = 1'b0;
        alu_ovf = 1'b0;
    endtask

    // Squashed store in the shadow must not reach memory.
    task automatic t_taken_store();
        clear_prog();
        br_eq = 1'b1;
        prog[0] = iop(6'h04, 5'd6, 5'd7, 16'd15);
        prog[2] = iop(6'h2B, 5'd1, 5'd2, 16'd0);
        release_rst();
        step(5);
        check("R8 squashed store quiet", {mem_v, mem_wr}, 2'b00);
        br_eq = 1'b0;
    endtask

    // Branch not taken: fall through, both followers complete.
    task automatic t_not_taken();
        clear_prog();
        br_eq = 1'b0;
        prog[0] = iop(6'h04, 5'd6, 5'd7, 16'd15);
        prog[1] = rop(6'h20, 5'd1, 5'd2, 5'd4);
        prog[2] = rop(6'h20, 5'd1, 5'd2, 5'd8);
        release_rst();
        step(2);
        check("R10 no redirect", 32'(pc_sel), 0);
        step(1);
        check("R10 sequential pc", 32'(pc), 12);
        step(3);
        check("R10 second follower write", {wb_we, wb_dst}, {1'b1, 5'd8});
    endtask

    // Load-use on rs: one bubble, fetch holds.
    task automatic t_stall_rs();
        clear_prog();
        prog[0] = iop(6'h23, 5'd1, 5'd5, 16'd0);
        prog[1] = rop(6'h20, 5'd5, 5'd2, 5'd6);
        prog[2] = rop(6'h20, 5'd1, 5'd2, 5'd7);
        release_rst();
        step(2);
        check("R6 hold raised", 32'(hold), 1);
        step(1);
        check("R6 pc held", 32'(pc), 8);
        check("R6 bubble in ex", {ex_v, id_v}, 2'b01);
        check("R6 decode kept", 32'(rs_a), 5);
        step(1);
        check("R6 pc resumes", 32'(pc), 12);
        check("R6 load write", {wb_we, wb_dst}, {1'b1, 5'd5});
        step(1);
        check("R8 bubble no write", {wb_v, wb_we}, 2'b00);
        step(1);
        check("R6 user write", {wb_we, wb_dst}, {1'b1, 5'd6});
        step(1);
        check("R6 next write", {wb_we, wb_dst}, {1'b1, 5'd7});
    endtask

    // Load-use on rt through a store.
    task automatic t_stall_rt();
        clear_prog();
        prog[0] = iop(6'h23, 5'd1, 5'd5, 16'd0);
        prog[1] = iop(6'h2B, 5'd1, 5'd5, 16'd0);
        release_rst();
        step(2);
        check("R6 rt hold", 32'(hold), 1);
    endtask

    // Destination-only match does not stall.
    task automatic t_no_stall();
        clear_prog();
        prog[0] = iop(6'h23, 5'd1, 5'd5, 16'd0);
        prog[1] = iop(6'h0D, 5'd3, 5'd5, 16'd1);
        release_rst();
        step(2);
        check("R11 no hold", 32'(hold), 0);
        step(1);
        check("R11 ex live", 32'(ex_v), 1);
        check("R11 pc advanced", 32'(pc), 12);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) prog[i] = 32'h0;
        t_mixed();
        t_taken();
        t_taken_store();
        t_not_taken();
        t_stall_rs();
        t_stall_rt();
        t_no_stall();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule